// File: doc/BRIEF.md
# Sync-Word Packet Deframer for Stereo Nibble Streams

This block takes bytes arriving from a serial receiver, one per cycle at most, and extracts fixed-length packets of compressed stereo audio. Nothing is passed on until it has seen four back-to-back copies of a constant marker byte. Once that header has been seen, it accepts exactly 256 payload bytes. There is no acknowledgement path, so packets simply follow one another. When the packet ends, the block goes back to hunting for the marker.

Each payload byte carries one 4-bit code for each channel. The block splits the byte and presents the two codes one after the other on a single code output, with a tag that names the channel. The consumer takes codes with a valid/ready handshake. If a new payload byte arrives while the previous byte is still being drained, the new byte replaces it and a sticky error flag is set.

Top module: `pkt_deframer`

## Requirements
- R1: While `rst` is high and on the cycle after it, `code_valid`, `locked`, `pkt_done` and `overflow` are all 0.
- R2: Four consecutive accepted bytes (`in_valid`=1) equal to `SYNC_BYTE` (default 0xA5) cause `locked` to be 1 from the cycle after the fourth byte.
- R3: Any accepted byte other than `SYNC_BYTE` during the hunt restarts the count, so four further marker bytes are needed before lock.
- R4: Bytes accepted while `locked` is 0 never produce a code on the output.
- R5: For each payload byte, bits [7:4] are emitted first with `code_chan`=0 (left), followed by bits [3:0] with `code_chan`=1 (right), and bytes are emitted in arrival order.
- R6: While `code_valid`=1 and `out_ready`=0, and no new payload byte arrives, `code_out` and `code_chan` stay stable.
- R7: The cycle after the 256th payload byte is accepted, `pkt_done` pulses high for one cycle and `locked` is 0. Bytes after that are dropped until a new header is seen.
- R8: `overflow` becomes 1 when a payload byte arrives while the previous byte's codes are not fully taken. This does not apply when its right code is taken in that same cycle. `overflow` stays 1 until reset.
- R9: A fifth marker byte directly after a header is treated as the first payload byte.
- R10: Cycles with `in_valid`=0 neither break nor advance the header count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | `in_byte` holds a new byte this cycle |
| out_ready | input | 1 | Consumer takes the presented code this cycle |
| code_out | output | 4 | Current 4-bit code |
| code_chan | output | 1 | Channel of `code_out`: 0 left, 1 right |
| code_valid | output | 1 | `code_out` holds a code |
| locked | output | 1 | Header seen, payload being accepted |
| pkt_done | output | 1 | One-cycle pulse after the last payload byte |
| overflow | output | 1 | Sticky flag: payload byte arrived before the previous byte was drained |

## Verification
The bench sends a full packet whose bytes follow a counting pattern XOR 0x3C. This makes every left/right nibble pair distinct, so a swapped or dropped code shows up in the comparison. Marker runs broken by a foreign byte and then resumed check the restart rule. A five-marker run checks that the extra marker is taken as payload rather than as part of the header. Idle gaps between marker bytes check that gaps are neither counted nor treated as breaks. Stalling the consumer, first for a single byte and then across two bytes, separates the hold behaviour from the overflow case. An unbroken packet sent at the drain rate shows that the flag is not raised when a right code leaves in the same cycle a new byte arrives.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

    typedef enum logic {
        FR_HUNT    = 1'b0,
        FR_PAYLOAD = 1'b1
    } frame_state_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_LEFT  = 2'd1,
        SLOT_RIGHT = 2'd2
    } slot_e;

    typedef struct packed {
        logic       chan;
        logic [3:0] code;
    } code_beat_t;

    // Match count after one accepted byte during the hunt.
    function automatic int unsigned next_match(input int unsigned cur, input logic hit);
        return hit ? cur + 1 : 0;
    endfunction

endpackage

// File: rtl/sync_hunter.sv
module sync_hunter #(
    parameter logic [7:0] SYNC_BYTE = 8'hA5,
    parameter int         SYNC_LEN  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hunting,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       header_found
);
    import deframer_pkg::*;

    localparam int CW = $clog2(SYNC_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(SYNC_LEN - 1);

    logic [CW-1:0] match_q;
    logic          hit;

    assign hit          = (byte_in == SYNC_BYTE);
    assign header_found = hunting && byte_valid && hit && (match_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
        end else if (!hunting) begin
            match_q <= '0;
        end else if (byte_valid) begin
            if (header_found)
                match_q <= '0;
            else
                match_q <= CW'(next_match(int'(match_q), hit));
        end
    end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
    parameter int PAYLOAD_LEN = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic header_found,
    input  logic byte_valid,
    output logic hunting,
    output logic accept,
    output logic locked,
    output logic pkt_done
);
    import deframer_pkg::*;

    localparam int PW = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(PAYLOAD_LEN - 1);

    frame_state_e state_q;
    logic [PW-1:0] count_q;

    assign hunting = (state_q == FR_HUNT);
    assign locked  = (state_q == FR_PAYLOAD);
    assign accept  = locked && byte_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FR_HUNT;
            count_q  <= '0;
            pkt_done <= 1'b0;
        end else begin
            pkt_done <= 1'b0;
            case (state_q)
                FR_HUNT: begin
                    count_q <= '0;
                    if (header_found)
                        state_q <= FR_PAYLOAD;
                end
                FR_PAYLOAD: begin
                    if (byte_valid) begin
                        if (count_q == LAST) begin
                            state_q  <= FR_HUNT;
                            count_q  <= '0;
                            pkt_done <= 1'b1;
                        end else begin
                            count_q <= count_q + 1'b1;
                        end
                    end
                end
                default: state_q <= FR_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/nibble_splitter.sv
module nibble_splitter #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [2*CODE_W-1:0] load_byte,
    input  logic              out_ready,
    output logic [CODE_W-1:0] code_out,
    output logic              code_chan,
    output logic              code_valid,
    output logic              overflow
);
    import deframer_pkg::*;

    slot_e               slot_q;
    logic [2*CODE_W-1:0] hold_q;
    logic                take;
    logic                drained;

    assign code_valid = (slot_q != SLOT_EMPTY);
    assign code_chan  = (slot_q == SLOT_RIGHT);
    assign code_out   = code_chan ? hold_q[CODE_W-1:0] : hold_q[2*CODE_W-1:CODE_W];
    assign take       = code_valid && out_ready;
    // Slot is free this cycle if empty or its last code leaves now.
    assign drained    = (slot_q == SLOT_EMPTY) || (slot_q == SLOT_RIGHT && out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= SLOT_EMPTY;
            hold_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (load) begin
                hold_q <= load_byte;
                slot_q <= SLOT_LEFT;
                if (!drained)
                    overflow <= 1'b1;
            end else if (take) begin
                slot_q <= (slot_q == SLOT_LEFT) ? SLOT_RIGHT : SLOT_EMPTY;
            end
        end
    end
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer #(
    parameter logic [7:0] SYNC_BYTE   = 8'hA5,
    parameter int         SYNC_LEN    = 4,
    parameter int         PAYLOAD_LEN = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_byte,
    input  logic       in_valid,
    input  logic       out_ready,
    output logic [3:0] code_out,
    output logic       code_chan,
    output logic       code_valid,
    output logic       locked,
    output logic       pkt_done,
    output logic       overflow
);
    import deframer_pkg::*;

    logic       hunting;
    logic       header_found;
    logic       accept;
    code_beat_t beat;

    sync_hunter #(.SYNC_BYTE(SYNC_BYTE), .SYNC_LEN(SYNC_LEN)) u_hunt (
        .clk(clk), .rst(rst), .hunting(hunting), .byte_valid(in_valid),
        .byte_in(in_byte), .header_found(header_found)
    );

    frame_sequencer #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_seq (
        .clk(clk), .rst(rst), .header_found(header_found), .byte_valid(in_valid),
        .hunting(hunting), .accept(accept), .locked(locked), .pkt_done(pkt_done)
    );

    nibble_splitter #(.CODE_W(4)) u_split (
        .clk(clk), .rst(rst), .load(accept), .load_byte(in_byte),
        .out_ready(out_ready), .code_out(beat.code), .code_chan(beat.chan),
        .code_valid(code_valid), .overflow(overflow)
    );

    assign code_out  = beat.code;
    assign code_chan = beat.chan;
endmodule

// File: rtl/pkt_deframer_chk.sv
module pkt_deframer_chk #(
    parameter logic [7:0] SYNC_BYTE = 8'hA5
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] in_byte,
    input logic       in_valid,
    input logic       out_ready,
    input logic [3:0] code_out,
    input logic       code_chan,
    input logic       code_valid,
    input logic       locked,
    input logic       pkt_done,
    input logic       overflow
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !code_valid && !locked && !overflow && !pkt_done);

    a_r2_lock_after_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(in_valid) && ($past(in_byte) == SYNC_BYTE));

    a_r4_hunt_drops: assert property (@(posedge clk) disable iff (rst)
        (!locked && in_valid && !code_valid) |=> !code_valid);

    a_r5_left_then_right: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !code_chan && out_ready && !(in_valid && locked)) |=> code_valid && code_chan);

    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !out_ready && !(in_valid && locked))
            |=> code_valid && $stable(code_out) && $stable(code_chan));

    a_r7_done_unlocks: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> !locked);

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind pkt_deframer pkt_deframer_chk #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .out_ready(out_ready), .code_out(code_out), .code_chan(code_chan),
    .code_valid(code_valid), .locked(locked), .pkt_done(pkt_done),
    .overflow(overflow)
);

// File: tb/sim_pkt_deframer.sv
module sim_pkt_deframer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_byte = 8'h00;
    logic       in_valid = 1'b0;
    logic       out_ready = 1'b1;
    logic [3:0] code_out;
    logic       code_chan;
    logic       code_valid;
    logic       locked;
    logic       pkt_done;
    logic       overflow;

    int n_checks = 0;
    int n_errors = 0;
    int n_got = 0;
    int n_done = 0;
    logic [4:0] got [0:1023];
    logic last_pd;
    logic last_lk;
    bit   finished = 0;

    always #5 clk = ~clk;

    pkt_deframer u0 (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
        .out_ready(out_ready), .code_out(code_out), .code_chan(code_chan),
        .code_valid(code_valid), .locked(locked), .pkt_done(pkt_done),
        .overflow(overflow)
    );

    // Record each code the consumer takes at the next rising edge.
    always @(negedge clk) begin
        if (!rst && code_valid && out_ready && n_got < 1024) begin
            got[n_got] = {code_chan, code_out};
            n_got++;
        end
        if (!rst && pkt_done) n_done++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_got = 0; n_done = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        in_byte = b; in_valid = 1'b1;
        @(negedge clk);
        last_pd = pkt_done; last_lk = locked;
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_header();
        for (int i = 0; i < 4; i++) send_byte(8'hA5, 1);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'h3C;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 code_valid", code_valid, 0);
        chk("R1 locked", locked, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 pkt_done", pkt_done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 locked after release", locked, 0);
    endtask

    task automatic t_full_packet();
        int bad;
        do_reset();
        send_byte(8'h11, 1);
        send_byte(8'hA5, 1); send_byte(8'hA5, 1); send_byte(8'hA5, 1);
        chk("R2 not locked after three", last_lk, 0);
        send_byte(8'hA5, 1);
        chk("R2 locked after four", last_lk, 1);
        chk("R4 nothing forwarded in hunt", n_got, 0);
        for (int i = 0; i < 256; i++) begin
            send_byte(pat(i), 1);
            if (i == 254) chk("R7 no early done", n_done, 0);
        end
        chk("R7 pkt_done after last byte", last_pd, 1);
        chk("R7 unlocked after last byte", last_lk, 0);
        @(negedge clk);
        chk("R7 pkt_done one cycle", pkt_done, 0);
        chk("R5 code count", n_got, 512);
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (got[2*i] !== {1'b0, pat(i)[7:4]}) bad++;
            if (got[2*i+1] !== {1'b1, pat(i)[3:0]}) bad++;
        end
        chk("R5 left then right codes", bad, 0);
        chk("R8 no overflow at drain rate", overflow, 0);
        send_byte(8'h77, 2);
        send_byte(8'hA5, 2);
        chk("R7 bytes after packet dropped", n_got, 512);
        chk("R4 still hunting", locked, 0);
    endtask

    task automatic t_restart();
        do_reset();
        send_byte(8'hA5, 1); send_byte(8'hA5, 1); send_byte(8'hA5, 1);
        send_byte(8'h12, 1);
        send_byte(8'hA5, 1); send_byte(8'hA5, 1); send_byte(8'hA5, 1);
        chk("R3 broken run not locked", last_lk, 0);
        chk("R4 broken run not forwarded", n_got, 0);
        send_byte(8'hA5, 1);
        chk("R3 locked after fresh four", last_lk, 1);
    endtask

    task automatic t_extra_sync();
        do_reset();
        send_header();
        send_byte(8'hA5, 2);
        chk("R9 fifth marker is payload", n_got, 2);
        chk("R9 left code", got[0], 5'h0A);
        chk("R9 right code", got[1], 5'h15);
        chk("R9 still locked", locked, 1);
    endtask

    task automatic t_gaps();
        do_reset();
        send_byte(8'hA5, 4); send_byte(8'hA5, 7);
        send_byte(8'hA5, 3);
        chk("R10 gaps do not lock early", last_lk, 0);
        send_byte(8'hA5, 5);
        chk("R10 gaps do not break run", last_lk, 1);
    endtask

    task automatic t_stall_and_overflow();
        do_reset();
        send_header();
        out_ready = 1'b0;
        send_byte(8'hC3, 0);
        repeat (5) @(negedge clk);
        chk("R6 valid held", code_valid, 1);
        chk("R6 left held", {code_chan, code_out}, 5'h0C);
        chk("R6 none taken", n_got, 0);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 drained after release", n_got, 2);
        chk("R6 right code", got[1], 5'h13);
        chk("R8 no overflow yet", overflow, 0);
        out_ready = 1'b0;
        send_byte(8'h5A, 0);
        send_byte(8'h6B, 0);
        chk("R8 overflow raised", overflow, 1);
        chk("R8 newer byte presented", {code_chan, code_out}, 5'h06);
        out_ready = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 overflow sticky", overflow, 1);
        do_reset();
        chk("R8 reset clears", overflow, 0);
    endtask

    initial begin
        t_reset();
        t_full_packet();
        t_restart();
        t_extra_sync();
        t_gaps();
        t_stall_and_overflow();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule